// File: doc/BRIEF.md
# Multiplexed Address-Latch Memory Bridge

This block lets a host that has only one byte-wide output bus and a few control pins reach a parallel memory of up to 128 KB. It also reaches up to three further byte-wide peripherals. The host's byte bus carries everything in turn. The low address byte, the high address byte and a command byte are each loaded into their own holding register by a dedicated strobe. The command byte carries the transfer direction and the topmost address bit. The host then raises exactly one of four select lines. The bridge asserts the matching chip enable and runs either a read or a write.

On a read, the bridge enables the device's outputs and passes the device byte back to the host for as long as the select is held. On a write, the bridge captures the host byte when the access starts. It then runs a fixed three-cycle sequence: set up the data, pulse the write enable, then hold the data. After that it releases the device and acknowledges. An access always ends when the host drops its select.

All pins are plain strobes and levels; there is no valid/ready stream, because the host paces each transfer with its select line. The bridge never drives the memory data lines except during its own write sequence. Raising two or more selects at once starts nothing and sets an error flag that stays set until reset.

Top module: `mem_bus_bridge`

## Requirements
- R1: After reset:
  - all chip enables, output enable and write enable are high (inactive);
  - `mem_dq_oe`, `host_rd_oe`, `acc_ack` and `err_multi` are 0;
  - `mem_addr` is 0.
- R2: While idle, each strobe loads its own register, and `mem_addr` shows the new value from the next clock edge:
  - `lo_stb` loads `mem_addr[7:0]` from `host_wdata`;
  - `hi_stb` loads `mem_addr[15:8]` from `host_wdata`;
  - `cmd_stb` loads the read flag from bit 7 (1 = read, 0 = write) and `mem_addr[16]` from bit 0.
  - Each register keeps its value until its own strobe loads it again.
- R3: Strobes that arrive while an access is in progress are ignored, and the address and direction stay unchanged.
- R4: In idle, a select vector with exactly one bit i set starts an access. From the next edge, `mem_ce_n[i]` is the only chip enable that is low.
- R5: A read access drives `mem_oe_n` low, raises `host_rd_oe` and `acc_ack`, and passes `mem_din` straight to `host_rdata`. All of this lasts until the first edge at which all selects are low.
- R6: A write access captures `host_wdata` at the start edge and then runs this sequence:
  - cycle 1: chip enable low, `mem_dq_oe` = 1, `mem_dout` = the captured data, write enable high;
  - cycle 2: write enable low;
  - cycle 3: write enable high again, with data and chip enable unchanged;
  - cycle 4 onwards: all chip enables high, `mem_dq_oe` = 0, `acc_ack` = 1, until the selects go low.
- R7: `mem_dq_oe` is 0 whenever no write sequence is running, including in idle and during reads. `host_rd_oe` is 1 only during a read.
- R8: A select vector with two or more bits set, seen in idle, enables no device and keeps `acc_ack` at 0. It sets `err_multi`, which stays 1 until reset. The bridge waits for all selects to go low.
- R9: Changes on the select lines during an access do not change which chip enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wdata | input | 8 | Host byte bus: address, command or write data |
| lo_stb | input | 1 | Load the low address byte |
| hi_stb | input | 1 | Load the high address byte |
| cmd_stb | input | 1 | Load the command byte (bit 7 read flag, bit 0 address bit 16) |
| host_sel | input | 4 | Peripheral select lines, one-hot when valid |
| host_rdata | output | 8 | Read data back to the host |
| host_rd_oe | output | 1 | Bridge drives the host bus with read data |
| acc_ack | output | 1 | Access finished or read data available |
| err_multi | output | 1 | Sticky flag for multiple selects |
| mem_addr | output | 17 | External address |
| mem_ce_n | output | 4 | Active-low chip enables |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 8 | Write data toward the memory |
| mem_dq_oe | output | 1 | Bridge drives the memory data lines |
| mem_din | input | 8 | Data from the memory |

## Verification
The hardest situations to reach are those in which host activity overlaps an access that is already running. One is a strobe pulsed in the middle of a read. Another is the select moving to a different line partway through. The stimulus produces both deliberately: it raises a strobe carrying a different byte, or swaps the select, while a read is held open. It then checks, once the bridge is idle again, that neither the address nor the enabled chip changed. Randomly chosen accesses reload either the low byte alone or all three bytes, so that the hold-until-reloaded behaviour is exercised across page boundaries.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_WSET = 3'd2,
    S_WSTB = 3'd3,
    S_WHLD = 3'd4,
    S_ACK  = 3'd5,
    S_BAD  = 3'd6
  } acc_state_t;
endpackage

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // holds until its own strobe (R2, R3 gating is done by the caller)
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/sel_check.sv
module sel_check #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  sel,
  output logic          any,
  output logic          multi,
  output logic [IW-1:0] idx
);
  logic [IW:0] cnt;
  always_comb begin
    cnt = '0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        cnt = cnt + 1'b1;
        idx = IW'(i);
      end
    end
  end
  assign any   = (cnt != '0);
  assign multi = (cnt > 1);
endmodule

// File: rtl/access_seq.sv
module access_seq
  import mbb_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_any,
  input  logic          sel_multi,
  input  logic [IW-1:0] sel_idx,
  input  logic          rd_flag,
  input  logic [DW-1:0] wdata,
  output logic          idle,
  output logic [N-1:0]  ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [DW-1:0] dout,
  output logic          dq_oe,
  output logic          rd_pass,
  output logic          ack,
  output logic          err
);
  acc_state_t    st, st_nx;
  logic [IW-1:0] cs_idx;
  logic [DW-1:0] wreg;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (sel_any) st_nx = sel_multi ? S_BAD : (rd_flag ? S_RD : S_WSET);
      S_RD:   if (!sel_any) st_nx = S_IDLE;
      S_WSET: st_nx = S_WSTB;
      S_WSTB: st_nx = S_WHLD;
      S_WHLD: st_nx = S_ACK;
      S_ACK:  if (!sel_any) st_nx = S_IDLE;
      S_BAD:  if (!sel_any) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cs_idx <= '0;
      wreg   <= '0;
      err    <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == S_IDLE && sel_any) begin
        if (sel_multi) err <= 1'b1;
        else begin
          cs_idx <= sel_idx;
          wreg   <= wdata;
        end
      end
    end
  end

  logic ce_on;
  assign ce_on = (st == S_RD) || (st == S_WSET) || (st == S_WSTB) || (st == S_WHLD);

  generate
    for (genvar g = 0; g < N; g++) begin : g_ce
      assign ce_n[g] = !(ce_on && (cs_idx == IW'(g)));
    end
  endgenerate

  assign idle    = (st == S_IDLE);
  assign oe_n    = (st != S_RD);
  assign we_n    = (st != S_WSTB);
  assign dq_oe   = (st == S_WSET) || (st == S_WSTB) || (st == S_WHLD);
  assign dout    = wreg;
  assign rd_pass = (st == S_RD);
  assign ack     = (st == S_RD) || (st == S_ACK);

  assert_one_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));
  assert_we_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> dq_oe && $past(dq_oe) && $stable(dout) && $stable(ce_n));
  assert_we_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe && $stable(ce_n) && $stable(dout));
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_multi_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle && sel_multi |=> (&ce_n) && err && !ack);
  assert_ce_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD) && $past(st == S_RD) |-> $stable(ce_n));
endmodule

// File: rtl/mem_bus_bridge.sv
module mem_bus_bridge #(
  parameter int DW     = 8,
  parameter int ADDR_W = 17,
  parameter int N_SEL  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     host_wdata,
  input  logic              lo_stb,
  input  logic              hi_stb,
  input  logic              cmd_stb,
  input  logic [N_SEL-1:0]  host_sel,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rd_oe,
  output logic              acc_ack,
  output logic              err_multi,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [N_SEL-1:0]  mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_din
);
  localparam int EXT_W = ADDR_W - 2 * DW;
  localparam int IW    = (N_SEL > 1) ? $clog2(N_SEL) : 1;

  logic            idle, sel_any, sel_multi, rd_pass;
  logic [IW-1:0]   sel_idx;
  logic [DW-1:0]   lo_q, hi_q;
  logic [EXT_W:0]  cmd_q;

  addr_latch #(.W(DW)) u_lo (
    .clk(clk), .rst_n(rst_n), .load(lo_stb && idle), .d(host_wdata), .q(lo_q));
  addr_latch #(.W(DW)) u_hi (
    .clk(clk), .rst_n(rst_n), .load(hi_stb && idle), .d(host_wdata), .q(hi_q));
  addr_latch #(.W(EXT_W + 1)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load(cmd_stb && idle),
    .d({host_wdata[DW-1], host_wdata[EXT_W-1:0]}), .q(cmd_q));

  sel_check #(.N(N_SEL), .IW(IW)) u_sel (
    .sel(host_sel), .any(sel_any), .multi(sel_multi), .idx(sel_idx));

  access_seq #(.N(N_SEL), .DW(DW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_any(sel_any), .sel_multi(sel_multi),
    .sel_idx(sel_idx), .rd_flag(cmd_q[EXT_W]), .wdata(host_wdata),
    .idle(idle), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .dout(mem_dout), .dq_oe(mem_dq_oe), .rd_pass(rd_pass),
    .ack(acc_ack), .err(err_multi));

  assign mem_addr   = {cmd_q[EXT_W-1:0], hi_q, lo_q};
  assign host_rd_oe = rd_pass;
  assign host_rdata = rd_pass ? mem_din : '0;

  assert_addr_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mem_addr));
  assert_rd_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_oe |-> !mem_oe_n && acc_ack && !(&mem_ce_n));
  assert_bus_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_dq_oe && !host_rd_oe);
endmodule

// File: tb/tb_mem_bus_bridge.sv
module tb_mem_bus_bridge;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  host_wdata = 0, mem_din = 0;
  logic        lo_stb = 0, hi_stb = 0, cmd_stb = 0;
  logic [3:0]  host_sel = 0;
  logic [7:0]  host_rdata, mem_dout;
  logic        host_rd_oe, acc_ack, err_multi, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [3:0]  mem_ce_n;

  int n_chk = 0, n_bad = 0;
  logic [16:0] e_addr = 0;
  logic        e_rd = 0, e_err = 0;

  mem_bus_bridge dut (.*);

  always #2.5 clk = ~clk;

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ce_of(input int i);
    return ~(4'b1 << i);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(input bit do_lo, input logic [7:0] lo, input bit do_hi,
                      input logic [7:0] hi, input bit do_cmd, input logic [7:0] cmd);
    if (do_lo) begin
      @(negedge clk); host_wdata = lo; lo_stb = 1; tick(); lo_stb = 0; e_addr[7:0] = lo;
    end
    if (do_hi) begin
      @(negedge clk); host_wdata = hi; hi_stb = 1; tick(); hi_stb = 0; e_addr[15:8] = hi;
    end
    if (do_cmd) begin
      @(negedge clk); host_wdata = cmd; cmd_stb = 1; tick(); cmd_stb = 0;
      e_addr[16] = cmd[0]; e_rd = cmd[7];
    end
    chk(mem_addr == e_addr, "R2 addr", mem_addr, e_addr);
  endtask

  task automatic do_write(input int i, input logic [7:0] d);
    @(negedge clk); host_sel = 4'b1 << i; host_wdata = d;
    tick();
    chk(mem_ce_n == ce_of(i) && mem_dq_oe && mem_dout == d && mem_we_n,
        "R6 setup", {mem_ce_n, mem_dq_oe, mem_we_n, mem_dout},
        {ce_of(i), 1'b1, 1'b1, d});
    chk(mem_addr == e_addr, "R6 addr", mem_addr, e_addr);
    host_wdata = ~d;
    tick();
    chk(!mem_we_n && mem_dq_oe && mem_dout == d && mem_ce_n == ce_of(i),
        "R6 strobe", {mem_ce_n, mem_dq_oe, mem_we_n, mem_dout}, {ce_of(i), 1'b1, 1'b0, d});
    tick();
    chk(mem_we_n && mem_dq_oe && mem_dout == d && mem_ce_n == ce_of(i),
        "R6 hold", {mem_ce_n, mem_dq_oe, mem_we_n, mem_dout}, {ce_of(i), 1'b1, 1'b1, d});
    tick();
    chk(mem_ce_n == 4'hF && !mem_dq_oe && acc_ack && !host_rd_oe,
        "R6 ack", {mem_ce_n, mem_dq_oe, acc_ack}, {4'hF, 1'b0, 1'b1});
    @(negedge clk); host_sel = 0;
    tick();
    chk(!acc_ack && !mem_dq_oe && mem_ce_n == 4'hF, "R7 idle after write",
        {acc_ack, mem_dq_oe}, 0);
  endtask

  task automatic do_read(input int i, input logic [7:0] d, input bit disturb);
    @(negedge clk); host_sel = 4'b1 << i; mem_din = d;
    tick();
    chk(mem_ce_n == ce_of(i) && !mem_oe_n && host_rd_oe && acc_ack && host_rdata == d,
        "R5 read", {mem_ce_n, mem_oe_n, host_rd_oe, acc_ack, host_rdata},
        {ce_of(i), 1'b0, 1'b1, 1'b1, d});
    chk(!mem_dq_oe && mem_we_n, "R7 no drive in read", mem_dq_oe, 0);
    @(negedge clk); mem_din = ~d; #1;
    chk(host_rdata == ~d, "R5 pass-through", host_rdata, ~d);
    if (disturb) begin
      host_wdata = ~e_addr[7:0]; lo_stb = 1; hi_stb = 1; cmd_stb = 1;
      host_sel = 4'b1 << ((i + 1) % 4);
      tick();
      lo_stb = 0; hi_stb = 0; cmd_stb = 0;
      chk(mem_ce_n == ce_of(i), "R9 chip fixed", mem_ce_n, ce_of(i));
    end
    @(negedge clk); host_sel = 0;
    tick();
    chk(!host_rd_oe && mem_oe_n && mem_ce_n == 4'hF && !acc_ack, "R5 release",
        {host_rd_oe, mem_oe_n, mem_ce_n}, {1'b0, 1'b1, 4'hF});
    chk(mem_addr == e_addr, "R3 addr unchanged", mem_addr, e_addr);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(mem_ce_n == 4'hF && mem_oe_n && mem_we_n && !mem_dq_oe && !host_rd_oe &&
        !acc_ack && !err_multi && mem_addr == 0, "R1 reset",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, host_rd_oe, acc_ack, err_multi},
        {4'hF, 3'b110, 3'b000});
    @(negedge clk); rst_n = 1;

    // directed: write then read, top address bit set
    load(1, 8'hFF, 1, 8'hFF, 1, 8'h01);
    do_write(0, 8'hA5);
    load(0, 0, 0, 0, 1, 8'h81);
    chk(mem_addr == 17'h1FFFF, "R2 bit16", mem_addr, 17'h1FFFF);
    do_read(3, 8'h5A, 1);  // R3 and R9 disturbance
    // direction flag held after a read (R3)
    do_read(2, 8'h3C, 0);

    // directed: multiple selects
    @(negedge clk); host_sel = 4'b0110;
    tick();
    chk(mem_ce_n == 4'hF && err_multi && !acc_ack, "R8 multi",
        {mem_ce_n, err_multi, acc_ack}, {4'hF, 1'b1, 1'b0});
    @(negedge clk); host_sel = 0; e_err = 1;
    tick();
    do_read(1, 8'h11, 0);
    chk(err_multi == e_err, "R8 sticky", err_multi, e_err);

    // random accesses
    for (int k = 0; k < 60; k++) begin
      int i = $urandom_range(3);
      logic [7:0] d = 8'($urandom);
      if ($urandom_range(1))
        load(1, 8'($urandom), 0, 0, 0, 0);
      else
        load(1, 8'($urandom), 1, 8'($urandom), 1, {1'($urandom), 6'd0, 1'($urandom)});
      if (e_rd) do_read(i, d, $urandom_range(3) == 0);
      else      do_write(i, d);
      chk(err_multi == e_err, "R8 flag", err_multi, e_err);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule